// File: doc/BRIEF.md
# Zero-Run Line Expander

This block rebuilds full-width pixel lines from a sprite stream in which the transparent pixels at both ends of each line have been stripped out. Every stored line begins with one 8-bit header byte whose two nibbles, each scaled by a programmable power of two, say how many zero pixels were removed at the start and at the end of the line. After the header come only the pixels that were kept. The expander emits the leading zeros, forwards the kept pixels, then emits the trailing zeros, so every output line has exactly the programmed width. An end-of-line flag marks the last pixel of each line.

The input carries header bytes and pixels on one valid/ready byte stream, with each pixel held in the low bits of a byte. The output is a valid/ready pixel stream. While zeros are being generated, the input is stalled. Kept pixels pass straight from input to output. The line width and the two multiplier codes are static settings, and they are captured at the moment each header is accepted.

Top module: `zrl_line_expander`

## Requirements
- R1: After reset, `in_ready` is 1 (the block is waiting for a header) and `out_valid` is 0.
- R2: In a header, bits [3:0] give the leading-zero count and bits [7:4] give the trailing-zero count. A line is output as the leading zeros, then the kept pixels, then the trailing zeros. For example, header 0x62 with both codes 00 gives 2 zeros, then the kept pixels, then 6 zeros.
- R3: Each nibble is multiplied by a factor set by its own 2-bit code: 00 gives x1, 01 gives x2, 10 gives x4 and 11 gives x8. `lead_code` scales the leading count and `trail_code` scales the trailing count. For example, header 0x62 with lead code 10 and trail code 11 gives 8 leading and 48 trailing zeros.
- R4: The number of kept pixels read for a line is `line_width` minus the leading count minus the trailing count. They are output in arrival order as `in_data[PIX_W-1:0]`.
- R5: Header 0x00 makes the line consist of all `line_width` input pixels, with no zeros added.
- R6: If the leading count plus the trailing count is greater than or equal to `line_width`, the line is `line_width` zeros. No pixel is read for it, and the next input byte is taken as the next header. This includes the case where the sum equals the width exactly.
- R7: While zeros are being output, `in_ready` is 0 and `out_data` is 0.
- R8: `out_eol` is 1 on exactly one pixel per line: the last of its `line_width` pixels.
- R9: While `out_ready` is 0, no pixel is lost or repeated, and a zero-run pixel stays presented.
- R10: `line_width`, `lead_code` and `trail_code` are sampled when the header is accepted. Changing them later in the line has no effect on that line.
- R11: `out_valid` is 0 while a header is being accepted. Each line's output starts in the cycle after its header is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_width | input | WIDTH_W | Output pixels per line (sampled at header) |
| lead_code | input | 2 | Leading-count multiplier code (sampled at header) |
| trail_code | input | 2 | Trailing-count multiplier code (sampled at header) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Header byte, or kept pixel in the low PIX_W bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready for an output pixel |
| out_data | output | PIX_W | Output pixel |
| out_eol | output | 1 | Last pixel of the current line |

## Verification
The in-design properties check the following on every cycle:
- the header state is silent (no output);
- zero runs keep the input stalled and drive zero data;
- the run counter never exceeds the pixels left in the line;
- an end-of-line handshake always returns the decoder to the header state;
- a stalled zero pixel stays presented.

Some behaviour can only be shown by the bench's scenarios, which compare the output against a model built from the requirements:
- the nibble split and the x1/x2/x4/x8 scaling;
- the exact kept-pixel count;
- the all-zero case at and above the width;
- the header-time capture of the settings;
- the pixel order under random backpressure.

// File: rtl/zrl_pkg.sv
package zrl_pkg;

    // Decoding phases of one line, visited in this order
    typedef enum logic [1:0] {
        ZS_HEADER = 2'd0,
        ZS_LEAD   = 2'd1,
        ZS_BODY   = 2'd2,
        ZS_TRAIL  = 2'd3
    } zrl_state_e;

    localparam int HDR_W = 8;

endpackage

// File: rtl/zrl_run_calc.sv
// Turns a header byte plus the line settings into the three phase lengths.
module zrl_run_calc #(
    parameter int WIDTH_W = 10
) (
    input  logic [7:0]         hdr_i,
    input  logic [1:0]         lead_code_i,
    input  logic [1:0]         trail_code_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic [WIDTH_W-1:0] lead_o,
    output logic [WIDTH_W-1:0] body_o,
    output logic [WIDTH_W-1:0] trail_o
);
    // A nibble times 8 needs 7 bits; one extra bit holds the sum
    localparam int BASE_W = (WIDTH_W > 7) ? WIDTH_W : 7;
    localparam int SW     = BASE_W + 2;

    logic [SW-1:0] lead_s, trail_s, sum_s, wid_s, body_s;
    logic          all_zero;

    always_comb begin
        lead_s   = SW'(hdr_i[3:0]) << lead_code_i;
        trail_s  = SW'(hdr_i[7:4]) << trail_code_i;
        sum_s    = lead_s + trail_s;
        wid_s    = SW'(width_i);
        all_zero = (sum_s >= wid_s);
        body_s   = wid_s - sum_s;
        // An over-full line becomes one zero run of the whole width
        lead_o   = all_zero ? width_i : WIDTH_W'(lead_s);
        body_o   = all_zero ? '0      : WIDTH_W'(body_s);
        trail_o  = all_zero ? '0      : WIDTH_W'(trail_s);
    end

endmodule

// File: rtl/zrl_line_fsm.sv
// Sequences header, leading zeros, kept pixels and trailing zeros.
module zrl_line_fsm
    import zrl_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int WIDTH_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               in_valid_i,
    input  logic [HDR_W-1:0]   in_data_i,
    output logic               in_ready_o,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [WIDTH_W-1:0] lead_i,
    input  logic [WIDTH_W-1:0] body_i,
    input  logic [WIDTH_W-1:0] trail_i,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [PIX_W-1:0]   out_data_o,
    output logic               out_eol_o
);
    localparam logic [WIDTH_W-1:0] CNT_ONE = {{(WIDTH_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        zrl_state_e         st;
        logic [WIDTH_W-1:0] cnt;    // pixels left in current phase
        logic [WIDTH_W-1:0] body;   // kept pixels still to come
        logic [WIDTH_W-1:0] trail;  // trailing zeros still to come
        logic [WIDTH_W-1:0] left;   // pixels left in the line
    } fsm_t;

    fsm_t r_q, r_d;
    logic fire;

    always_comb begin
        r_d         = r_q;
        in_ready_o  = 1'b0;
        out_valid_o = 1'b0;
        out_data_o  = '0;
        out_eol_o   = (r_q.st != ZS_HEADER) && (r_q.left == CNT_ONE);

        unique case (r_q.st)
            ZS_HEADER: begin
                in_ready_o = 1'b1;
            end
            ZS_LEAD, ZS_TRAIL: begin
                out_valid_o = 1'b1;
            end
            default: begin
                out_valid_o = in_valid_i;
                in_ready_o  = out_ready_i;
                out_data_o  = PIX_W'(in_data_i);
            end
        endcase

        fire = out_valid_o && out_ready_i;

        if (r_q.st == ZS_HEADER) begin
            if (in_valid_i) begin
                r_d.left  = width_i;
                r_d.body  = body_i;
                r_d.trail = trail_i;
                if (lead_i != '0) begin
                    r_d.st  = ZS_LEAD;
                    r_d.cnt = lead_i;
                end else if (body_i != '0) begin
                    r_d.st  = ZS_BODY;
                    r_d.cnt = body_i;
                end else if (trail_i != '0) begin
                    r_d.st  = ZS_TRAIL;
                    r_d.cnt = trail_i;
                end
            end
        end else if (fire) begin
            r_d.left = r_q.left - CNT_ONE;
            r_d.cnt  = r_q.cnt - CNT_ONE;
            if (r_q.cnt == CNT_ONE) begin
                if (r_q.st == ZS_LEAD && r_q.body != '0) begin
                    r_d.st  = ZS_BODY;
                    r_d.cnt = r_q.body;
                end else if (r_q.st != ZS_TRAIL && r_q.trail != '0) begin
                    r_d.st  = ZS_TRAIL;
                    r_d.cnt = r_q.trail;
                end else begin
                    r_d.st  = ZS_HEADER;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ZS_HEADER, cnt: '0, body: '0, trail: '0, left: '0};
        end else begin
            r_q <= r_d;
        end
    end

    AST_HDR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ZS_HEADER) |-> !out_valid_o) else $error("header state emitted"); // R11

    AST_RUN_STALLS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ZS_LEAD || r_q.st == ZS_TRAIL) |-> (!in_ready_o && out_data_o == '0))
        else $error("zero run let input through"); // R7

    AST_EOL_TO_HEADER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_ready_i && out_eol_o) |=> (r_q.st == ZS_HEADER))
        else $error("line did not end at eol"); // R8

    AST_RUN_WITHIN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st != ZS_HEADER) |-> (r_q.cnt != '0 && r_q.cnt <= r_q.left))
        else $error("phase longer than line"); // R8

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && r_q.st != ZS_BODY) |=> (out_valid_o && $stable(r_q.left)))
        else $error("stalled zero dropped"); // R9

endmodule

// File: rtl/zrl_line_expander.sv
// Expands header-compressed sprite lines to full width.
module zrl_line_expander
    import zrl_pkg::*;
#(
    parameter int PIX_W   = 8,   // 1..8
    parameter int WIDTH_W = 10   // at least 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH_W-1:0] line_width,
    input  logic [1:0]         lead_code,
    input  logic [1:0]         trail_code,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [HDR_W-1:0]   in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_data,
    output logic               out_eol
);
    logic [WIDTH_W-1:0] lead_w, body_w, trail_w;

    zrl_run_calc #(.WIDTH_W(WIDTH_W)) u_calc (
        .hdr_i        (in_data),
        .lead_code_i  (lead_code),
        .trail_code_i (trail_code),
        .width_i      (line_width),
        .lead_o       (lead_w),
        .body_o       (body_w),
        .trail_o      (trail_w)
    );

    zrl_line_fsm #(.PIX_W(PIX_W), .WIDTH_W(WIDTH_W)) u_fsm (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_ready_o  (in_ready),
        .width_i     (line_width),
        .lead_i      (lead_w),
        .body_i      (body_w),
        .trail_i     (trail_w),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data),
        .out_eol_o   (out_eol)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid)) else $error("not idle after reset"); // R1

endmodule

// File: tb/sim_zrl_line_expander.sv
module sim_zrl_line_expander;
    localparam int PIX_W   = 8;
    localparam int WIDTH_W = 10;

    typedef struct {
        logic [7:0] d;
        bit         eol;
        bit         fill;
        string      tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [WIDTH_W-1:0] line_width = '0;
    logic [1:0]         lead_code = '0, trail_code = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [7:0]         in_data = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [PIX_W-1:0]   out_data;
    logic               out_eol;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   hdr_phase = 0;
    bit   bp_on = 0;
    bit   done = 0;
    int   seed = 1;
    logic [7:0] lf = 8'hA5;

    always #4 clk = ~clk;   // 125 MHz

    zrl_line_expander #(.PIX_W(PIX_W), .WIDTH_W(WIDTH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .line_width(line_width),
        .lead_code(lead_code), .trail_code(trail_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_eol(out_eol)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] pix(int s, int k);
        return 8'((s * 37 + k * 11 + 5) & 255);
    endfunction

    // Consumer readiness: pseudo-random when backpressure is on
    always @(posedge clk) begin
        #1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        out_ready = bp_on ? lf[0] : 1'b1;
    end

    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_line(input logic [7:0] hdr, input int w,
                             input logic [1:0] lc, input logic [1:0] tc,
                             input string tag, input bit mess);
        int lead, trail, nb, s;
        exp_t e;
        s     = seed;
        seed  = seed + 1;
        lead  = int'(hdr[3:0]) << lc;
        trail = int'(hdr[7:4]) << tc;
        if (lead + trail >= w) begin
            nb = 0;
            for (int i = 0; i < w; i++) begin
                e = '{d: 8'h00, eol: (i == w - 1), fill: 1, tag: tag};
                q.push_back(e);
            end
        end else begin
            nb = w - lead - trail;
            for (int i = 0; i < w; i++) begin
                if (i < lead || i >= lead + nb)
                    e = '{d: 8'h00, eol: (i == w - 1), fill: 1, tag: tag};
                else
                    e = '{d: pix(s, i - lead), eol: (i == w - 1), fill: 0, tag: tag};
                q.push_back(e);
            end
        end
        line_width = WIDTH_W'(w);
        lead_code  = lc;
        trail_code = tc;
        hdr_phase  = 1;
        put_byte(hdr);
        hdr_phase  = 0;
        if (mess) begin
            line_width = WIDTH_W'(w) ^ 10'h0A5;
            lead_code  = ~lc;
            trail_code = ~tc;
        end
        for (int k = 0; k < nb; k++) put_byte(pix(s, k));
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (hdr_phase && in_ready && in_valid) begin
                checks++;
                if (out_valid) begin
                    errors++;
                    $display("FAIL R11 out_valid during header act %b exp 0", out_valid);
                end
            end
            if (out_valid && out_ready) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected pixel act %h exp none", out_data);
                end else begin
                    e = q.pop_front();
                    if (out_data !== e.d[PIX_W-1:0] || out_eol !== e.eol) begin
                        errors++;
                        $display("FAIL %s/R8 data act %h exp %h eol act %b exp %b",
                                 e.tag, out_data, e.d, out_eol, e.eol);
                    end
                    if (e.fill && in_ready) begin
                        errors++;
                        $display("FAIL R7 in_ready during zero run act %b exp 0", in_ready);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act running exp finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset in_ready act %b exp 1 out_valid act %b exp 0",
                     in_ready, out_valid);
        end
        @(posedge clk); #1;

        send_line(8'h62, 16, 2'b00, 2'b00, "R2", 0);   // 2 lead, 8 kept, 6 trail
        send_line(8'h62, 64, 2'b10, 2'b11, "R3", 0);   // 8 lead, 8 kept, 48 trail
        send_line(8'h21, 20, 2'b01, 2'b01, "R3", 0);   // 2 lead, 14 kept, 4 trail
        send_line(8'h13, 12, 2'b00, 2'b00, "R4", 0);   // 3 lead, 8 kept, 1 trail
        send_line(8'h00, 12, 2'b11, 2'b11, "R5", 0);   // whole line kept
        send_line(8'hFF, 20, 2'b00, 2'b00, "R6", 0);   // over-full: 20 zeros
        send_line(8'h55, 10, 2'b00, 2'b00, "R6", 0);   // sum equals width
        send_line(8'h54, 10, 2'b00, 2'b00, "R6", 0);   // one kept pixel
        send_line(8'h07, 14, 2'b00, 2'b00, "R2", 0);   // no trailing zeros
        send_line(8'h30, 9,  2'b00, 2'b00, "R2", 0);   // no leading zeros
        send_line(8'h32, 24, 2'b01, 2'b00, "R10", 1);  // settings changed mid-line
        send_line(8'h11, 18, 2'b00, 2'b00, "R10", 0);  // next line uses new settings
        bp_on = 1;
        send_line(8'h62, 30, 2'b00, 2'b01, "R9", 0);
        send_line(8'h00, 10, 2'b00, 2'b00, "R9", 0);
        send_line(8'h24, 16, 2'b01, 2'b00, "R9", 0);
        send_line(8'hF3, 12, 2'b00, 2'b00, "R9", 0);   // over-full under stall

        wait (q.size() == 0);
        bp_on = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 idle after lines out_valid act %b exp 0 in_ready act %b exp 1",
                     out_valid, in_ready);
        end
        finish_run();
    end

endmodule